// File: doc/BRIEF.md
# Multi-Cycle Processor-Side Operation Unit

This unit sits beside a small processor's arithmetic unit and runs one operation each time the processor issues a custom instruction to it. The processor provides two 32-bit register operands, an 8-bit operation selector and the register-file routing fields of the instruction. It raises `start` for one enabled cycle. Some cycles later the unit answers with a single-cycle `done` pulse and a 32-bit `result`. The unit never touches memory and works only on the operands it is handed.

Two operations are defined. Selector 0 folds one data byte into a running CRC-32, one bit per enabled cycle. Selector 1 adds the operands through a short pipeline. Every other selector value answers zero after a single cycle. The register indices and routing flags are captured when an instruction is accepted. They are presented on `tag_out` together with the result, so the processor's write-back logic can route the answer. The processor's clock enable freezes the whole unit.

Top module: `xop_engine`

## Requirements
- R1: While reset is applied and until the first accepted start, `done` is 0, `result` is 0 and `tag_out` is 0. Reset is asynchronous and active low, and its release is synchronised internally over two clock edges.
- R2: In a cycle with `clk_en` low, `start` is not accepted and no internal state changes. Latencies count only rising edges at which `clk_en` is high. `done` reads 0 while `clk_en` is low.
- R3: Each accepted start produces `done` high in exactly one cycle with `clk_en` high. If the operation latency is L, that cycle follows the L-th enabled edge after the accepting edge.
- R4: `result` and `tag_out` change only at the edge that raises `done`. They keep their value until the next completion.
- R5: Selector 0 runs a CRC step with latency 8. `opa` is the running CRC. `opb[7:0]` is shifted in MSB first with polynomial 0x04C11DB7, with no reflection and no final inversion. `opb[31:8]` has no effect.
- R6: Selector 1 returns `opa + opb` modulo 2^32 with latency 2.
- R7: Any selector from 2 to 255 returns 0 with latency 1.
- R8: A `start` that arrives while an operation is in flight is ignored. It produces no extra `done` and does not alter the pending result.
- R9: `tag_out` packs the fields captured at acceptance: bits [17:13] `idx_a`, [12:8] `idx_b`, [7:3] `idx_c`, [2] `rd_int_a`, [1] `rd_int_b`, [0] `wr_int_c`.
- R10: A `start` in the cycle that shows `done` is accepted, so operations can be issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Processor clock enable; low freezes the unit |
| start | input | 1 | Issue request for one operation |
| opsel | input | 8 | Operation selector |
| opa | input | 32 | First operand (running CRC for selector 0) |
| opb | input | 32 | Second operand (data byte in bits 7:0 for selector 0) |
| idx_a | input | 5 | Register index of the first operand |
| idx_b | input | 5 | Register index of the second operand |
| idx_c | input | 5 | Register index of the destination |
| rd_int_a | input | 1 | First operand comes from the processor's internal register file |
| rd_int_b | input | 1 | Second operand comes from the processor's internal register file |
| wr_int_c | input | 1 | Destination is the processor's internal register file |
| result | output | 32 | Operation result, valid with done |
| tag_out | output | 18 | Captured routing fields, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong latency count or a stuck busy flag shows up at `done`. The pulse arrives one or more enabled cycles early or late, or never. A per-cycle comparison against a behavioural model therefore catches the error on the very cycle the expected pulse is due. A corrupted CRC or adder stage stays hidden until completion and then appears as a wrong `result` in the `done` cycle. A lost or mis-latched routing field appears on `tag_out` in that same cycle. State that moves while `clk_en` is low, or a start accepted while busy, shifts the timing of the next `done` and so also surfaces within one operation.

// File: rtl/xop_pkg.sv
`timescale 1ns/1ps
package xop_pkg;
  localparam int OPC_CRC = 0;
  localparam int OPC_ADD = 1;

  typedef enum logic [1:0] {
    K_CRC  = 2'd0,
    K_ADD  = 2'd1,
    K_ZERO = 2'd2
  } kind_e;
endpackage

// File: rtl/xop_rst_sync.sv
`timescale 1ns/1ps
module xop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/xop_ctrl.sv
`timescale 1ns/1ps
module xop_ctrl #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             start,
  input  logic [CNT_W-1:0] lat_in,
  output logic             accept,
  output logic             step,
  output logic             finish,
  output logic             busy,
  output logic             done_q
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_d;

  assign accept = clk_en & start & ~busy_q;
  assign step   = clk_en & busy_q;
  assign finish = step & (cnt_q == '0);
  assign busy   = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (clk_en) begin
      done_d = finish;
      if (accept) begin
        busy_d = 1'b1;
        cnt_d  = lat_in - CNT_W'(1);
      end else if (step) begin
        if (cnt_q == '0) busy_d = 1'b0;
        else             cnt_d  = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/xop_crc_serial.sv
`timescale 1ns/1ps
module xop_crc_serial #(
  parameter int             W    = 32,
  parameter int             BW   = 8,
  parameter logic [W-1:0]   POLY = 32'h04C11DB7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [W-1:0]  seed,
  input  logic [BW-1:0] data,
  output logic [W-1:0]  crc_next
);
  logic [W-1:0]  crc_q, crc_d;
  logic [BW-1:0] sh_q, sh_d;
  logic          fb;

  assign fb       = crc_q[W-1] ^ sh_q[BW-1];
  assign crc_next = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_comb begin
    crc_d = crc_q;
    sh_d  = sh_q;
    if (load) begin
      crc_d = seed;
      sh_d  = data;
    end else if (step) begin
      crc_d = crc_next;
      sh_d  = {sh_q[BW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
      sh_q  <= '0;
    end else begin
      crc_q <= crc_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/xop_add_pipe.sv
`timescale 1ns/1ps
module xop_add_pipe #(
  parameter int W   = 32,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum_out
);
  localparam int NSTG = LAT - 1;

  logic [W-1:0]            a_q, b_q, a_d, b_d;
  logic [NSTG-1:0][W-1:0]  stg_q, stg_d;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    stg_d = stg_q;
    if (load) begin
      a_d = a;
      b_d = b;
    end
    if (step) begin
      stg_d[0] = a_q + b_q;
      for (int i = 1; i < NSTG; i++) stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      stg_q <= '0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      stg_q <= stg_d;
    end
  end

  assign sum_out = stg_q[NSTG-1];
endmodule

// File: rtl/xop_engine.sv
`timescale 1ns/1ps
module xop_engine #(
  parameter int                DATA_W    = 32,
  parameter int                SEL_W     = 8,
  parameter int                IDX_W     = 5,
  parameter int                CRC_BYTE  = 8,
  parameter logic [DATA_W-1:0] CRC_POLY  = 32'h04C11DB7,
  parameter int                ADD_LAT   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_en,
  input  logic                 start,
  input  logic [SEL_W-1:0]     opsel,
  input  logic [DATA_W-1:0]    opa,
  input  logic [DATA_W-1:0]    opb,
  input  logic [IDX_W-1:0]     idx_a,
  input  logic [IDX_W-1:0]     idx_b,
  input  logic [IDX_W-1:0]     idx_c,
  input  logic                 rd_int_a,
  input  logic                 rd_int_b,
  input  logic                 wr_int_c,
  output logic [DATA_W-1:0]    result,
  output logic [3*IDX_W+2:0]   tag_out,
  output logic                 done
);
  import xop_pkg::*;

  localparam int MAX_LAT = (CRC_BYTE > ADD_LAT) ? CRC_BYTE : ADD_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);
  localparam int TAG_W   = 3*IDX_W + 3;

  logic              rst_sync_n;
  logic              accept, step, finish, busy, done_q;
  kind_e             kind_in, kind_q, kind_d;
  logic [CNT_W-1:0]  lat_sel;
  logic [TAG_W-1:0]  tag_in, ptag_q, ptag_d, tag_q, tag_d;
  logic [DATA_W-1:0] res_q, res_d, crc_val, sum_val;

  xop_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    if (opsel == SEL_W'(OPC_CRC)) begin
      kind_in = K_CRC;
      lat_sel = CNT_W'(CRC_BYTE);
    end else if (opsel == SEL_W'(OPC_ADD)) begin
      kind_in = K_ADD;
      lat_sel = CNT_W'(ADD_LAT);
    end else begin
      kind_in = K_ZERO;
      lat_sel = CNT_W'(1);
    end
  end

  assign tag_in = {idx_a, idx_b, idx_c, rd_int_a, rd_int_b, wr_int_c};

  xop_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .clk_en(clk_en), .start(start),
    .lat_in(lat_sel), .accept(accept), .step(step), .finish(finish),
    .busy(busy), .done_q(done_q)
  );

  xop_crc_serial #(.W(DATA_W), .BW(CRC_BYTE), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_sync_n), .load(accept), .step(step),
    .seed(opa), .data(opb[CRC_BYTE-1:0]), .crc_next(crc_val)
  );

  xop_add_pipe #(.W(DATA_W), .LAT(ADD_LAT)) u_add (
    .clk(clk), .rst_n(rst_sync_n), .load(accept), .step(step),
    .a(opa), .b(opb), .sum_out(sum_val)
  );

  always_comb begin
    kind_d = kind_q;
    ptag_d = ptag_q;
    res_d  = res_q;
    tag_d  = tag_q;
    if (accept) begin
      kind_d = kind_in;
      ptag_d = tag_in;
    end
    if (finish) begin
      tag_d = ptag_q;
      case (kind_q)
        K_CRC:   res_d = crc_val;
        K_ADD:   res_d = sum_val;
        default: res_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      kind_q <= K_ZERO;
      ptag_q <= '0;
      res_q  <= '0;
      tag_q  <= '0;
    end else begin
      kind_q <= kind_d;
      ptag_q <= ptag_d;
      res_q  <= res_d;
      tag_q  <= tag_d;
    end
  end

  assign result  = res_q;
  assign tag_out = tag_q;
  assign done    = done_q & clk_en;
endmodule

// File: rtl/xop_engine_chk.sv
`timescale 1ns/1ps
module xop_engine_chk #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 8,
  parameter int TAG_W  = 18
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              clk_en,
  input logic              start,
  input logic [SEL_W-1:0]  opsel,
  input logic              busy,
  input logic              done_q,
  input logic              done,
  input logic [1:0]        kind_q,
  input logic [DATA_W-1:0] result,
  input logic [TAG_W-1:0]  tag_out
);
  // R3
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R2
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !clk_en |=> ($stable(result) && $stable(tag_out)));

  // R4
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_q |-> ($stable(result) && $stable(tag_out)));

  // R7
  zero_res_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_q && kind_q == 2'd2) |-> (result == '0));

  // R5
  crc_not_early_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en && start && !busy && opsel == '0) |=> !done_q);
endmodule

bind xop_engine xop_engine_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .clk_en(clk_en), .start(start),
  .opsel(opsel), .busy(busy), .done_q(done_q), .done(done),
  .kind_q(kind_q), .result(result), .tag_out(tag_out)
);

// File: tb/test_xop_engine.sv
`timescale 1ns/1ps
module test_xop_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clk_en, start;
  logic [7:0]  opsel;
  logic [31:0] opa, opb;
  logic [4:0]  idx_a, idx_b, idx_c;
  logic        rd_int_a, rd_int_b, wr_int_c;
  logic [31:0] result;
  logic [17:0] tag_out;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xop_engine i_xop_engine (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start), .opsel(opsel),
    .opa(opa), .opb(opb), .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .rd_int_a(rd_int_a), .rd_int_b(rd_int_b), .wr_int_c(wr_int_c),
    .result(result), .tag_out(tag_out), .done(done)
  );

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] x = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = x[31] ^ d[i];
      x = {x[30:0], 1'b0};
      if (fb) x = x ^ 32'h04C11DB7;
    end
    return x;
  endfunction

  function automatic int lat_of(input logic [7:0] s);
    if (s == 8'd0) return 8;
    if (s == 8'd1) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] val_of(input logic [7:0] s, input logic [31:0] a, input logic [31:0] b);
    if (s == 8'd0) return crc_ref(a, b[7:0]);
    if (s == 8'd1) return a + b;
    return 32'd0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_cnt;
  bit          m_done;
  logic [31:0] m_res, m_pres;
  logic [17:0] m_tag, m_ptag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_res = '0; m_pres = '0; m_tag = '0; m_ptag = '0;
    end else if (clk_en) begin
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_res = m_pres; m_tag = m_ptag;
        end else m_done = 0;
      end else begin
        m_done = 0;
        if (start) begin
          m_cnt  = lat_of(opsel);
          m_pres = val_of(opsel, opa, opb);
          m_ptag = {idx_a, idx_b, idx_c, rd_int_a, rd_int_b, wr_int_c};
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check(done == (m_done && clk_en), "R3 done", 32'(done), 32'(m_done && clk_en));
      check(result == m_res, "R4 result", result, m_res);
      check(tag_out == m_tag, "R9 tag", 32'(tag_out), 32'(m_tag));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_done(output int k);
    k = 0;
    while (k < 60) begin
      @(negedge clk);
      k++;
      if (done) break;
    end
  endtask

  task automatic run_op(input logic [7:0] s, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp, input string req);
    int k;
    @(posedge clk); #1;
    opsel = s; opa = a; opb = b; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done(k);
    check(k == lat_of(s) + 1, req, 32'(k), 32'(lat_of(s) + 1));
    check(result == exp, req, result, exp);
  endtask

  initial begin
    int k;
    rst_n = 1'b0; clk_en = 1'b1; start = 1'b0; opsel = '0; opa = '0; opb = '0;
    idx_a = '0; idx_b = '0; idx_c = '0; rd_int_a = 0; rd_int_b = 0; wr_int_c = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0 && result == '0 && tag_out == '0, "R1", result, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0 && result == '0 && tag_out == '0, "R1", result, 32'd0);

    // R6 add
    run_op(8'd1, 32'd5, 32'd7, 32'd12, "R6");
    run_op(8'd1, 32'hFFFF_FFFF, 32'd2, 32'd1, "R6");

    // R5 crc
    run_op(8'd0, 32'd0, 32'h0000_0001, 32'h04C1_1DB7, "R5");
    run_op(8'd0, 32'd0, 32'h1234_5601, 32'h04C1_1DB7, "R5");
    run_op(8'd0, 32'hFFFF_FFFF, 32'h0000_00A5, crc_ref(32'hFFFF_FFFF, 8'hA5), "R5");

    // R7 other selectors
    run_op(8'd2, 32'd9, 32'd9, 32'd0, "R7");
    run_op(8'd255, 32'd9, 32'd9, 32'd0, "R7");

    // R4 hold
    repeat (5) @(negedge clk);
    check(result == 32'd0 && !done, "R4", result, 32'd0);

    // R9 tag packing
    @(posedge clk); #1;
    idx_a = 5'd17; idx_b = 5'd3; idx_c = 5'd30; rd_int_a = 1; rd_int_b = 0; wr_int_c = 1;
    run_op(8'd1, 32'd100, 32'd1, 32'd101, "R9");
    check(tag_out == {5'd17, 5'd3, 5'd30, 1'b1, 1'b0, 1'b1}, "R9",
          32'(tag_out), 32'({5'd17, 5'd3, 5'd30, 1'b1, 1'b0, 1'b1}));

    // R2 start ignored with clk_en low
    @(posedge clk); #1;
    clk_en = 1'b0; start = 1'b1; opsel = 8'd2;
    repeat (3) @(posedge clk); #1;
    start = 1'b0; clk_en = 1'b1;
    k = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) k++;
    end
    check(k == 0, "R2", 32'(k), 32'd0);

    // R2 stall mid-operation stretches latency
    @(posedge clk); #1;
    opsel = 8'd0; opa = 32'h0; opb = 32'h1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; clk_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 clk_en = 1'b1;
    wait_done(k);
    check(k == 9, "R2", 32'(k), 32'd9);
    check(result == 32'h04C1_1DB7, "R2", result, 32'h04C1_1DB7);

    // R8 start while busy
    @(posedge clk); #1;
    opsel = 8'd0; opa = 32'h0; opb = 32'h1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    opsel = 8'd1; opa = 32'd100; opb = 32'd1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done(k);
    check(result == 32'h04C1_1DB7, "R8", result, 32'h04C1_1DB7);
    k = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) k++;
    end
    check(k == 0, "R8", 32'(k), 32'd0);

    // R10 back to back
    @(posedge clk); #1;
    opsel = 8'd1; opa = 32'd3; opb = 32'd4; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk);
    @(posedge clk); #1;
    opa = 32'd10; opb = 32'd20; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_done(k);
    check(k == 3, "R10", 32'(k), 32'd3);
    check(result == 32'd30, "R10", result, 32'd30);

    // random traffic against the model (R2 R3 R4 R8)
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      clk_en = ($urandom % 4) != 0;
      start  = ($urandom % 3) == 0;
      case ($urandom % 3)
        0: opsel = 8'd0;
        1: opsel = 8'd1;
        default: opsel = 8'($urandom);
      endcase
      opa = $urandom; opb = $urandom;
      idx_a = 5'($urandom); idx_b = 5'($urandom); idx_c = 5'($urandom);
      rd_int_a = 1'($urandom); rd_int_b = 1'($urandom); wr_int_c = 1'($urandom);
    end
    @(posedge clk); #1;
    start = 1'b0; clk_en = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule